// File: doc/BRIEF.md
# Two-Level Aperture Address Translator

This block maps addresses that fall inside a graphics aperture window onto physical memory. The first translation level is a small directory held in on-chip flops; each directory slot names a table page in memory, and each table page holds 1024 second-level entries of 32 bits. Software fills the directory one slot at a time by writing a single packed 32-bit load word. The same word also clears a slot.

Requests are handled one at a time. For each accepted request the block checks that the address lies inside the configured window and picks a directory slot. It then either answers from a one-entry translation cache or fetches the second-level entry over a valid/ready read port with variable latency. The answer is a one-cycle response that carries either a translated address or a fault flag. The cache is emptied by a write to the control register that takes the flush bit from 1 to 0, and also by any directory load.

Top module: `aper_xlate`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` and `mem_req_valid` are 0, and the translation cache is empty, so the first in-window request reads memory.
- R2: A load word sets the slot picked by bits 5:0 to the table page in bits 31:20, with bit 8 as the present flag. Bits 19:9 and 7:6 have no effect. A load with bit 8 at 0 makes the slot non-present.
- R3: The slot is `addr[31:22] - base[31:22]`. Size code 0 gives 64 slots, 32 gives 32, 48 gives 16 and 56 gives 8. Any other code gives none. A request below the base, or one whose slot is not below the slot count, faults with no memory read.
- R4: A request that hits a non-present slot faults with no memory read. Its response appears in the cycle after acceptance.
- R5: A walk reads address `{page[11:0], 8'h00, addr[21:12], 2'b00}`. `mem_req_valid` and the address are held steady until `mem_req_ready`.
- R6: If bit 0 of the fetched entry is 1, the response address is `{entry[31:12], addr[11:0]}` with the fault flag at 0. If bit 0 is 0, including an all-zero entry, the response is a fault with address 0. The response comes in the cycle after the entry arrives.
- R7: A request on the same 4 KB page as the cached translation responds in the cycle after acceptance, without a memory read. Only successful walks fill the cache.
- R8: A control write with the flush bit (bit 7) at 0, while the held value has it at 1, empties the cache. Control writes that do not lower bit 7 leave the cache unchanged. The control register resets to 0x2280.
- R9: A directory load made during a walk does not change that walk's fetch or result. It empties the cache, and the walk's result is not cached.
- R10: `req_ready` stays 0 from the start of a walk until its response, so only one translation is in flight.
- R11: `rsp_valid` pulses exactly once per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | 32 | Aperture base address (bits 31:22 used) |
| cfg_size | input | 8 | Aperture size code |
| ld_we | input | 1 | Directory load strobe |
| ld_data | input | 32 | Packed directory load word |
| ctl_we | input | 1 | Control register write strobe |
| ctl_data | input | 32 | Control register write value |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | Aperture address to translate |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Response is a fault |
| rsp_addr | output | 32 | Translated physical address, 0 on fault |
| mem_req_valid | output | 1 | Table-entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Table-entry byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Second-level entry |

## Verification
The bench builds the block with its default parameters: 64 directory slots, a control reset value of 0x2280 and bit 7 as the flush bit. These settings reach all four size codes, slot-count boundaries of 8, 16, 32 and 64, and the flush sequence exactly as software issues it. The memory model stalls the read handshake for one cycle and varies the response latency, so the hold rule and the mid-walk directory load can both be observed. Cache hits and misses are inferred at the ports from the number of memory reads and from response latency.

// File: rtl/aper_pkg.sv
package aper_pkg;

  localparam int PG_SHIFT  = 12;
  localparam int IDX_W     = 10;
  localparam int DIR_SHIFT = 22;
  localparam int PRES_BIT  = 8;
  localparam int PAGE_W    = 12;
  localparam int VPN_W     = 32 - PG_SHIFT;

  typedef struct packed {
    logic              present;
    logic [PAGE_W-1:0] page;
  } dir_ent_t;

  typedef enum logic [1:0] {W_IDLE, W_REQ, W_WAIT} walk_st_t;

  // Slot count for an aperture size code; unknown codes open no slots.
  function automatic logic [10:0] size_slots(input logic [7:0] code);
    case (code)
      8'd0:    return 11'd64;
      8'd32:   return 11'd32;
      8'd48:   return 11'd16;
      8'd56:   return 11'd8;
      default: return 11'd0;
    endcase
  endfunction

  function automatic logic [9:0] dir_offset(input logic [31:0] addr,
                                            input logic [31:0] base);
    return addr[31:DIR_SHIFT] - base[31:DIR_SHIFT];
  endfunction

  function automatic logic [31:0] entry_addr(input logic [PAGE_W-1:0] page,
                                             input logic [31:0] addr);
    return {page, 8'h00, addr[DIR_SHIFT-1:PG_SHIFT], 2'b00};
  endfunction

  function automatic logic [31:0] join_addr(input logic [VPN_W-1:0] ppn,
                                            input logic [31:0] addr);
    return {ppn, addr[PG_SHIFT-1:0]};
  endfunction

endpackage

// File: rtl/aper_dir.sv
module aper_dir
  import aper_pkg::*;
#(
  parameter int SLOTS  = 64,
  parameter int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  dir_ent_t          wr_ent,
  input  logic [SLOT_W-1:0] rd_slot,
  output dir_ent_t          rd_ent
);

  dir_ent_t ents [SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        ents[s] <= '0;
      else if (wr_en && (wr_slot == SLOT_W'(s)))
        ents[s] <= wr_ent;
    end
  end

  assign rd_ent = ents[rd_slot];

endmodule

// File: rtl/aper_tlb.sv
module aper_tlb
  import aper_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inv,
  input  logic             fill,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [VPN_W-1:0] fill_ppn,
  input  logic [VPN_W-1:0] look_vpn,
  output logic             hit,
  output logic             valid,
  output logic [VPN_W-1:0] ppn
);

  logic [VPN_W-1:0] vpn_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      vpn_q <= '0;
      ppn   <= '0;
    end else if (inv) begin
      valid <= 1'b0;
    end else if (fill) begin
      valid <= 1'b1;
      vpn_q <= fill_vpn;
      ppn   <= fill_ppn;
    end
  end

  assign hit = valid && (vpn_q == look_vpn);

endmodule

// File: rtl/aper_walk.sv
module aper_walk
  import aper_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] start_maddr,
  output logic        busy,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [31:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  output logic        done
);

  walk_st_t st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= W_IDLE;
      mem_req_addr <= '0;
    end else begin
      case (st)
        W_IDLE: if (start) begin
          st           <= W_REQ;
          mem_req_addr <= start_maddr;
        end
        W_REQ:  if (mem_req_ready) st <= W_WAIT;
        W_WAIT: if (mem_rsp_valid) st <= W_IDLE;
        default: st <= W_IDLE;
      endcase
    end
  end

  assign busy          = (st != W_IDLE);
  assign mem_req_valid = (st == W_REQ);
  assign done          = (st == W_WAIT) && mem_rsp_valid;

endmodule

// File: rtl/aper_xlate.sv
module aper_xlate
  import aper_pkg::*;
#(
  parameter int          DIR_SLOTS = 64,
  parameter logic [31:0] CTL_RESET = 32'h0000_2280,
  parameter int          FLUSH_BIT = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] cfg_base,
  input  logic [7:0]  cfg_size,
  input  logic        ld_we,
  input  logic [31:0] ld_data,
  input  logic        ctl_we,
  input  logic [31:0] ctl_data,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_addr,
  output logic        rsp_valid,
  output logic        rsp_fault,
  output logic [31:0] rsp_addr,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [31:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data
);

  localparam int SLOT_W = $clog2(DIR_SLOTS);
  localparam logic [10:0] MAX_SLOTS = 11'(DIR_SLOTS);

  // Named internal events, observed by the bound checker.
  logic ev_accept, ev_tlb_hit, ev_walk_start, ev_fast_fault;
  logic ev_walk_done, ev_flush, ev_dir_write;

  logic [31:0] ctl_q;
  logic [31:0] addr_q;
  logic        stale_q;
  logic        walk_busy;
  logic [9:0]  slot_off;
  logic [10:0] slot_lim;
  logic        in_rng;
  dir_ent_t    dir_rd;
  dir_ent_t    dir_wr;
  logic        tlb_hit, tlb_valid, tlb_fill, tlb_inv;
  logic [VPN_W-1:0] tlb_ppn;

  logic unused_bits;
  assign unused_bits = ^{ld_data[19:9], ld_data[7:SLOT_W], cfg_base[21:0],
                         mem_rsp_data[11:1]};

  // Window check and slot selection
  assign slot_off = dir_offset(req_addr, cfg_base);
  assign slot_lim = (size_slots(cfg_size) > MAX_SLOTS) ? MAX_SLOTS : size_slots(cfg_size);
  assign in_rng   = (req_addr[31:DIR_SHIFT] >= cfg_base[31:DIR_SHIFT]) &&
                    ({1'b0, slot_off} < slot_lim);

  assign req_ready     = !walk_busy;
  assign ev_accept     = req_valid && req_ready;
  assign ev_tlb_hit    = ev_accept && in_rng && tlb_hit;
  assign ev_walk_start = ev_accept && in_rng && !tlb_hit && dir_rd.present;
  assign ev_fast_fault = ev_accept && !ev_tlb_hit && !ev_walk_start;
  assign ev_flush      = ctl_we && ctl_q[FLUSH_BIT] && !ctl_data[FLUSH_BIT];
  assign ev_dir_write  = ld_we;

  assign dir_wr.present = ld_data[PRES_BIT];
  assign dir_wr.page    = ld_data[31:32-PAGE_W];

  aper_dir #(.SLOTS(DIR_SLOTS), .SLOT_W(SLOT_W)) u_dir (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ev_dir_write),
    .wr_slot (ld_data[SLOT_W-1:0]),
    .wr_ent  (dir_wr),
    .rd_slot (slot_off[SLOT_W-1:0]),
    .rd_ent  (dir_rd)
  );

  assign tlb_inv  = ev_flush || ev_dir_write;
  assign tlb_fill = ev_walk_done && mem_rsp_data[0] && !stale_q;

  aper_tlb u_tlb (
    .clk      (clk),
    .rst_n    (rst_n),
    .inv      (tlb_inv),
    .fill     (tlb_fill),
    .fill_vpn (addr_q[31:PG_SHIFT]),
    .fill_ppn (mem_rsp_data[31:PG_SHIFT]),
    .look_vpn (req_addr[31:PG_SHIFT]),
    .hit      (tlb_hit),
    .valid    (tlb_valid),
    .ppn      (tlb_ppn)
  );

  aper_walk u_walk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (ev_walk_start),
    .start_maddr   (entry_addr(dir_rd.page, req_addr)),
    .busy          (walk_busy),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .done          (ev_walk_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q   <= CTL_RESET;
      addr_q  <= '0;
      stale_q <= 1'b0;
    end else begin
      if (ctl_we) ctl_q <= ctl_data;
      if (ev_accept) addr_q <= req_addr;
      if (ev_walk_start) stale_q <= tlb_inv;
      else if (tlb_inv)  stale_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_addr  <= '0;
    end else begin
      rsp_valid <= ev_tlb_hit || ev_fast_fault || ev_walk_done;
      rsp_fault <= ev_fast_fault || (ev_walk_done && !mem_rsp_data[0]);
      if (ev_tlb_hit)
        rsp_addr <= join_addr(tlb_ppn, req_addr);
      else if (ev_walk_done && mem_rsp_data[0])
        rsp_addr <= join_addr(mem_rsp_data[31:PG_SHIFT], addr_q);
      else
        rsp_addr <= '0;
    end
  end

endmodule

// File: rtl/aper_xlate_chk.sv
module aper_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        ev_accept,
  input logic        ev_walk_start,
  input logic        ev_tlb_hit,
  input logic        ev_walk_done,
  input logic        ev_flush,
  input logic        ev_dir_write,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [31:0] mem_req_addr,
  input logic        mem_rsp_data0,
  input logic        rsp_valid,
  input logic        rsp_fault,
  input logic [31:0] rsp_addr,
  input logic        tlb_valid
);

  assert_fast_path_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept && !ev_walk_start |=> rsp_valid && !mem_req_valid);

  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  assert_entry_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_walk_done |=> rsp_valid && (rsp_fault == !$past(mem_rsp_data0)));

  assert_fault_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_addr == 32'h0);

  assert_hit_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tlb_hit |=> rsp_valid && !rsp_fault);

  assert_inval_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_flush || ev_dir_write |=> !tlb_valid);

  assert_single_flight_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_walk_start |=> !req_ready);

  assert_busy_no_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);

  assert_rsp_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(ev_accept && !ev_walk_start) || $past(ev_walk_done));

endmodule

bind aper_xlate aper_xlate_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .ev_accept     (ev_accept),
  .ev_walk_start (ev_walk_start),
  .ev_tlb_hit    (ev_tlb_hit),
  .ev_walk_done  (ev_walk_done),
  .ev_flush      (ev_flush),
  .ev_dir_write  (ev_dir_write),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_data0 (mem_rsp_data[0]),
  .rsp_valid     (rsp_valid),
  .rsp_fault     (rsp_fault),
  .rsp_addr      (rsp_addr),
  .tlb_valid     (tlb_valid)
);

// File: tb/aper_xlate_tb.sv
module aper_xlate_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] cfg_base;
  logic [7:0]  cfg_size;
  logic        ld_we, ctl_we, req_valid;
  logic [31:0] ld_data, ctl_data, req_addr;
  logic        req_ready, rsp_valid, rsp_fault;
  logic [31:0] rsp_addr;
  logic        mem_req_valid, mem_req_ready, mem_rsp_valid;
  logic [31:0] mem_req_addr, mem_rsp_data;

  int checks = 0;
  int fails  = 0;
  int reads  = 0;
  int hold_cnt = 0;
  int cur_lat = 0;
  logic [31:0] cur_entry = '0;
  logic [31:0] last_maddr = '0;
  logic [11:0] bpage [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  aper_xlate u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_size(cfg_size),
    .ld_we(ld_we), .ld_data(ld_data), .ctl_we(ctl_we), .ctl_data(ctl_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_addr(rsp_addr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic [31:0] entry;
    logic [3:0]  lat;
    logic        fault;
    logic [1:0]  nrd;
    logic [31:0] exp;
  } vec_t;

  // base 0x4000_0000, size code 0 (64 slots)
  localparam vec_t VEC [9] = '{
    '{32'h4000_5678, 32'h8765_4001, 4'd0, 1'b0, 2'd1, 32'h8765_4678}, // walk, slot 0
    '{32'h4000_5ABC, 32'h0000_0000, 4'd0, 1'b0, 2'd0, 32'h8765_4ABC}, // R7 hit
    '{32'h407F_F010, 32'h0000_0000, 4'd2, 1'b1, 2'd1, 32'h0},         // R6 zero entry, top index
    '{32'h40C0_1000, 32'h0000_0000, 4'd0, 1'b1, 2'd0, 32'h0},         // R2 R4 cleared slot 3
    '{32'h3FFF_F000, 32'h0000_0000, 4'd0, 1'b1, 2'd0, 32'h0},         // R3 below base
    '{32'h41C0_2004, 32'hABCD_E001, 4'd5, 1'b0, 2'd1, 32'hABCD_E004}, // R2 slot 7 junk bits
    '{32'h4000_9FFF, 32'h1111_1000, 4'd1, 1'b1, 2'd1, 32'h0},         // R6 bit 0 clear
    '{32'h4000_9000, 32'h2222_3001, 4'd0, 1'b0, 2'd1, 32'h2222_3000}, // R7 fault not cached
    '{32'h5000_0000, 32'h0000_0000, 4'd0, 1'b1, 2'd0, 32'h0}          // R3 slot 64
  };

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_maddr(input logic [11:0] pg, input logic [31:0] a);
    return (32'(pg) << 20) | (((a >> 12) & 32'h3FF) << 2);
  endfunction

  // memory model: one stall cycle before ready, then latency cur_lat
  initial begin
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      if (mem_req_valid && !mem_req_ready) begin
        if (hold_cnt == 1) begin
          mem_req_ready = 1'b1;
          reads++;
          last_maddr = mem_req_addr;
          hold_cnt = 0;
        end else hold_cnt++;
      end else if (mem_req_ready) begin
        mem_req_ready = 1'b0;
        repeat (cur_lat) @(negedge clk);
        mem_rsp_data  = cur_entry;
        mem_rsp_valid = 1'b1;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
      end
    end
  end

  task automatic ld(input logic [31:0] w);
    @(negedge clk);
    ld_we = 1'b1; ld_data = w;
    @(negedge clk);
    ld_we = 1'b0;
    bpage[w[5:0]] = w[31:20];
  endtask

  task automatic ctl(input logic [31:0] w);
    @(negedge clk);
    ctl_we = 1'b1; ctl_data = w;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic run(input logic [31:0] a, input logic [31:0] e, input int lat,
                     input bit mid, input logic [31:0] midw,
                     output bit f, output logic [31:0] ra, output int nrd, output int cyc);
    int r0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    cur_entry = e; cur_lat = lat; r0 = reads;
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1;
    if (mid) begin
      @(negedge clk); cyc++;
      chk(!req_ready, "R10 ready low during walk", 32'(req_ready), 32'h0);
      ld_we = 1'b1; ld_data = midw;
      @(negedge clk); cyc++;
      ld_we = 1'b0;
    end
    while (!rsp_valid && cyc < 200) begin @(negedge clk); cyc++; end
    f = rsp_fault; ra = rsp_addr; nrd = reads - r0;
    @(negedge clk);
    chk(!rsp_valid || req_ready, "R11 single response pulse", 32'(rsp_valid), 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    report();
    $finish;
  end

  initial begin
    bit f; logic [31:0] ra; int nrd; int cyc; logic [31:0] ma0;
    rst_n = 1'b0; cfg_base = 32'h4000_0000; cfg_size = 8'd0;
    ld_we = 0; ld_data = 0; ctl_we = 0; ctl_data = 0; req_valid = 0; req_addr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 reset req_ready", 32'(req_ready), 32'h1);
    chk(rsp_valid == 1'b0, "R1 reset rsp_valid", 32'(rsp_valid), 32'h0);
    chk(mem_req_valid == 1'b0, "R1 reset mem_req_valid", 32'(mem_req_valid), 32'h0);

    ld(32'h1230_0100);  // slot 0 page 0x123
    ld(32'h0AB0_0101);  // slot 1 page 0x0AB
    ld(32'h0330_0103);  // slot 3 present
    ld(32'h0330_0003);  // R2 slot 3 cleared
    ld(32'h777F_FFC7);  // R2 slot 7 page 0x777, junk in 19:9 and 7:6

    // R1: first request with a fresh cache must read memory (vector 0)
    for (int i = 0; i < 9; i++) begin
      run(VEC[i].addr, VEC[i].entry, int'(VEC[i].lat), 1'b0, 32'h0, f, ra, nrd, cyc);
      chk(f == VEC[i].fault, $sformatf("R6 fault flag vec%0d", i), 32'(f), 32'(VEC[i].fault));
      chk(ra == VEC[i].exp, $sformatf("R6 response address vec%0d", i), ra, VEC[i].exp);
      chk(nrd == int'(VEC[i].nrd), $sformatf("R3 R4 R7 read count vec%0d", i), 32'(nrd), 32'(VEC[i].nrd));
      if (VEC[i].nrd != 0)
        chk(last_maddr == exp_maddr(bpage[(VEC[i].addr - cfg_base) >> 22], VEC[i].addr),
            $sformatf("R5 entry address vec%0d", i), last_maddr,
            exp_maddr(bpage[(VEC[i].addr - cfg_base) >> 22], VEC[i].addr));
      else
        chk(cyc == 1, $sformatf("R4 R7 one-cycle response vec%0d", i), 32'(cyc), 32'h1);
    end

    // R8 flush sequence
    run(32'h4000_A000, 32'h5555_5001, 0, 0, 0, f, ra, nrd, cyc);
    run(32'h4000_A010, 32'h0, 0, 0, 0, f, ra, nrd, cyc);
    chk(nrd == 0 && ra == 32'h5555_5010, "R7 hit before flush", ra, 32'h5555_5010);
    ctl(32'h0000_2200);
    run(32'h4000_A020, 32'h5555_5001, 0, 0, 0, f, ra, nrd, cyc);
    chk(nrd == 1, "R8 falling bit 7 flushes", 32'(nrd), 32'h1);
    ctl(32'h0000_2280);
    run(32'h4000_A030, 32'h0, 0, 0, 0, f, ra, nrd, cyc);
    chk(nrd == 0, "R8 rising bit 7 keeps cache", 32'(nrd), 32'h0);
    ctl(32'h0000_2280);
    run(32'h4000_A040, 32'h0, 0, 0, 0, f, ra, nrd, cyc);
    chk(nrd == 0, "R8 repeated 0x2280 keeps cache", 32'(nrd), 32'h0);
    ctl(32'h0000_2200);
    run(32'h4000_A050, 32'h5555_5001, 0, 0, 0, f, ra, nrd, cyc);
    ctl(32'h0000_2200);
    run(32'h4000_A060, 32'h0, 0, 0, 0, f, ra, nrd, cyc);
    chk(nrd == 0 && ra == 32'h5555_5060, "R8 bit 7 already low keeps cache", ra, 32'h5555_5060);

    // R9 load during walk
    run(32'h4002_0123, 32'h3333_3001, 10, 1'b1, 32'h4560_0100, f, ra, nrd, cyc);
    ma0 = last_maddr;
    bpage[0] = 12'h456;
    chk(ma0 == 32'h1230_0080, "R9 walk keeps old page", ma0, 32'h1230_0080);
    chk(ra == 32'h3333_3123 && !f, "R9 walk result", ra, 32'h3333_3123);
    run(32'h4002_0123, 32'h4444_4001, 0, 0, 0, f, ra, nrd, cyc);
    chk(nrd == 1, "R9 result not cached", 32'(nrd), 32'h1);
    chk(last_maddr == 32'h4560_0080, "R9 new page after walk", last_maddr, 32'h4560_0080);
    chk(ra == 32'h4444_4123, "R9 new translation", ra, 32'h4444_4123);

    // R2 clear slot 1 then request
    ld(32'h0AB0_0001);
    run(32'h4040_1000, 32'h9999_9001, 0, 0, 0, f, ra, nrd, cyc);
    chk(f && nrd == 0, "R2 present bit clear invalidates", 32'(nrd), 32'h0);

    // R3 size codes
    ld(32'h8880_0108);  // slot 8 page 0x888
    cfg_size = 8'd56;
    run(32'h4200_0000, 32'h0, 0, 0, 0, f, ra, nrd, cyc);
    chk(f && nrd == 0, "R3 code 56 slot 8 outside", 32'(f), 32'h1);
    run(32'h41C0_3000, 32'h6666_6001, 0, 0, 0, f, ra, nrd, cyc);
    chk(!f && ra == 32'h6666_6000, "R3 code 56 slot 7 inside", ra, 32'h6666_6000);
    cfg_size = 8'd48;
    run(32'h4200_1000, 32'h7777_7001, 0, 0, 0, f, ra, nrd, cyc);
    chk(!f && last_maddr == 32'h8880_0004, "R3 code 48 slot 8 inside", last_maddr, 32'h8880_0004);
    cfg_size = 8'd32;
    run(32'h4800_0000, 32'h0, 0, 0, 0, f, ra, nrd, cyc);
    chk(f && nrd == 0, "R3 code 32 slot 32 outside", 32'(nrd), 32'h0);
    cfg_size = 8'd5;
    run(32'h4000_0000, 32'h0, 0, 0, 0, f, ra, nrd, cyc);
    chk(f && nrd == 0 && cyc == 1, "R3 unknown code faults", 32'(f), 32'h1);

    report();
    $finish;
  end

endmodule